// File: doc/BRIEF.md
# TV Raster Line Timing and Bar Pattern Generator

This block produces the horizontal timing of a monochrome television line and a simple bar test pattern, all from one system clock that is nominally 4 MHz. A chain of two 4-bit divide-by-16 stages forms an 8-bit line position. The low stage wraps every 16 clocks, which gives a 250 kHz tick, and the whole chain wraps every 256 clocks, which gives the 15625 Hz line rate. Registered window logic, driven by that position, produces a blanking pulse and a sync pulse that sits inside it.

A small selector picks a horizontal pattern source and a vertical pattern source. The horizontal source is a slow divider bit for wide stripes, the 250 kHz tick for thin lines, or a constant high. The vertical source is a bit from an external line counter or a constant high. The video level is the NAND of the two sources, forced low during blanking. Sync is a separate output, which a downstream analog mixer combines with the video.

Top module: `raster_line_gen`

## Requirements
- R1: The line position p (0..255) advances by one every clock and wraps after 255, so `blank_o` rises exactly once every 256 clocks.
- R2: `blank_o` is high for line positions 0 to 47 (48 clocks) and low for positions 48 to 255.
- R3: `sync_o` is high for line positions 8 to 23 (16 clocks, starting 8 clocks after blanking starts) and is never high while `blank_o` is low.
- R4: With `hsel_i` = 2'b01 (stripes), the horizontal source is bit 4 of p, which is the least significant bit of the upper divider stage.
- R5: With `hsel_i` = 2'b10 (lines), the horizontal source is the low-stage tick, which is high when p[3:0] = 15. With `hsel_i` = 2'b00 or 2'b11, the horizontal source is a constant 1.
- R6: With `vsel_i` = 1, the vertical source is `vbit_i`. With `vsel_i` = 0, it is a constant 1.
- R7: Outside blanking, `video_o` is the NAND of the horizontal and vertical sources. During blanking, `video_o` is 0.
- R8: All outputs are registered. The value seen after a rising clock edge reflects the line position and the inputs that were present at that edge.
- R9: An asynchronous active-low `rst_n` gives `blank_o`=1, `sync_o`=0 and `video_o`=0, and restarts the line at position 0. After release, the first edge shows position 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel-rate clock, nominally 4 MHz |
| rst_n | input | 1 | Asynchronous active-low reset |
| hsel_i | input | 2 | Horizontal source: 01 stripes, 10 lines, 00/11 constant high |
| vsel_i | input | 1 | 1 selects `vbit_i` as the vertical source, 0 selects constant high |
| vbit_i | input | 1 | Bit from an external line counter |
| blank_o | output | 1 | Horizontal blanking pulse |
| sync_o | output | 1 | Horizontal sync pulse |
| video_o | output | 1 | Digital video level |

## Verification
Every output has a latency of one clock. After edge k following reset release, the outputs show line position k-1 and the select inputs that were driven before edge k. The bench changes its inputs just after each falling edge and compares the outputs at the next falling edge. Each comparison is made against the position and inputs recorded for the edge that lies between the two. A reset asserted in mid-line is checked before the next rising edge, because its effect is asynchronous. The count then restarts at position 0.

// File: rtl/raster_pkg.sv
package raster_pkg;
  typedef enum logic [1:0] {
    HSRC_FLAT_A = 2'b00,
    HSRC_STRIPE = 2'b01,
    HSRC_TICK   = 2'b10,
    HSRC_FLAT_B = 2'b11
  } hsrc_e;
endpackage

// File: rtl/raster_divchain.sv
module raster_divchain #(
  parameter int STAGE_W = 4,
  parameter int NSTAGE  = 2,
  localparam int POS_W  = STAGE_W * NSTAGE
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [POS_W-1:0] pos_o,
  output logic             tick_o
);
  logic [NSTAGE:0] stage_en;
  assign stage_en[0] = 1'b1;

  for (genvar g = 0; g < NSTAGE; g++) begin : g_stage
    logic [STAGE_W-1:0] cnt_q, cnt_d;
    always_comb begin
      cnt_d = cnt_q;
      if (stage_en[g]) cnt_d = cnt_q + 1'b1;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt_q <= '0;
      else        cnt_q <= cnt_d;
    end
    assign stage_en[g+1] = stage_en[g] & (&cnt_q);
    assign pos_o[g*STAGE_W +: STAGE_W] = cnt_q;
  end

  assign tick_o = stage_en[1];
endmodule

// File: rtl/raster_hwin.sv
module raster_hwin #(
  parameter int POS_W     = 8,
  parameter int BLANK_LEN = 48,
  parameter int SYNC_OFS  = 8,
  parameter int SYNC_LEN  = 16,
  localparam int SYNC_END = SYNC_OFS + SYNC_LEN
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [POS_W-1:0] pos_i,
  output logic             blank_d_o,
  output logic             blank_o,
  output logic             sync_o
);
  logic blank_q, sync_q, sync_d;

  always_comb begin
    blank_d_o = blank_q;
    if (pos_i == POS_W'(0))              blank_d_o = 1'b1;
    else if (pos_i == POS_W'(BLANK_LEN)) blank_d_o = 1'b0;
    sync_d = sync_q;
    if (pos_i == POS_W'(SYNC_OFS))       sync_d = 1'b1;
    else if (pos_i == POS_W'(SYNC_END))  sync_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      blank_q <= 1'b1;
      sync_q  <= 1'b0;
    end else begin
      blank_q <= blank_d_o;
      sync_q  <= sync_d;
    end
  end

  assign blank_o = blank_q;
  assign sync_o  = sync_q;
endmodule

// File: rtl/raster_pat.sv
module raster_pat #(
  parameter int POS_W      = 8,
  parameter int STRIPE_BIT = 4
) (
  input  logic [POS_W-1:0] pos_i,
  input  logic             tick_i,
  input  logic [1:0]       hsel_i,
  input  logic             vsel_i,
  input  logic             vbit_i,
  output logic             pat_o
);
  import raster_pkg::*;
  logic hsrc, vsrc;

  always_comb begin
    case (hsrc_e'(hsel_i))
      HSRC_STRIPE: hsrc = pos_i[STRIPE_BIT];
      HSRC_TICK:   hsrc = tick_i;
      default:     hsrc = 1'b1;
    endcase
    vsrc  = vsel_i ? vbit_i : 1'b1;
    pat_o = ~(hsrc & vsrc);
  end
endmodule

// File: rtl/raster_line_gen.sv
module raster_line_gen #(
  parameter int STAGE_W   = 4,
  parameter int NSTAGE    = 2,
  parameter int BLANK_LEN = 48,
  parameter int SYNC_OFS  = 8,
  parameter int SYNC_LEN  = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] hsel_i,
  input  logic       vsel_i,
  input  logic       vbit_i,
  output logic       blank_o,
  output logic       sync_o,
  output logic       video_o
);
  localparam int POS_W = STAGE_W * NSTAGE;

  logic [POS_W-1:0] pos;
  logic             tick, blank_d, pat, video_q, video_d;

  raster_divchain #(.STAGE_W(STAGE_W), .NSTAGE(NSTAGE)) u_div (
    .clk(clk), .rst_n(rst_n), .pos_o(pos), .tick_o(tick));

  raster_hwin #(.POS_W(POS_W), .BLANK_LEN(BLANK_LEN), .SYNC_OFS(SYNC_OFS),
                .SYNC_LEN(SYNC_LEN)) u_hwin (
    .clk(clk), .rst_n(rst_n), .pos_i(pos), .blank_d_o(blank_d),
    .blank_o(blank_o), .sync_o(sync_o));

  raster_pat #(.POS_W(POS_W), .STRIPE_BIT(STAGE_W)) u_pat (
    .pos_i(pos), .tick_i(tick), .hsel_i(hsel_i), .vsel_i(vsel_i),
    .vbit_i(vbit_i), .pat_o(pat));

  always_comb video_d = blank_d ? 1'b0 : pat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) video_q <= 1'b0;
    else        video_q <= video_d;
  end

  assign video_o = video_q;
endmodule

// File: rtl/raster_line_gen_chk.sv
module raster_line_gen_chk #(
  parameter int LINE_LEN  = 256,
  parameter int BLANK_LEN = 48,
  parameter int SYNC_OFS  = 8,
  parameter int SYNC_LEN  = 16
) (
  input logic clk,
  input logic rst_n,
  input logic blank_o,
  input logic sync_o,
  input logic video_o
);
  int unsigned q;
  logic        run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q   <= 0;
      run <= 1'b0;
    end else begin
      run <= 1'b1;
      if (run) q <= (q == LINE_LEN - 1) ? 0 : q + 1;
    end
  end

  AST_BLANK_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    blank_o == (q < BLANK_LEN)); // R2
  AST_SYNC_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    sync_o == (q >= SYNC_OFS && q < SYNC_OFS + SYNC_LEN)); // R3
  AST_SYNC_INSIDE_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
    sync_o |-> blank_o); // R3
  AST_VIDEO_BLANKED: assert property (@(posedge clk) disable iff (!rst_n)
    blank_o |-> !video_o); // R7
  AST_LINE_START: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(blank_o) |-> q == 0); // R1
endmodule

bind raster_line_gen raster_line_gen_chk #(
  .LINE_LEN(1 << (STAGE_W * NSTAGE)), .BLANK_LEN(BLANK_LEN),
  .SYNC_OFS(SYNC_OFS), .SYNC_LEN(SYNC_LEN)
) u_chk (
  .clk(clk), .rst_n(rst_n), .blank_o(blank_o), .sync_o(sync_o),
  .video_o(video_o));

// File: tb/test_raster_line_gen.sv
module test_raster_line_gen;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] hsel;
  logic       vsel, vbit;
  logic       blank, sync, video;

  int n_cmp = 0;
  int n_bad = 0;
  int p;
  int last_rise;
  int samp;
  logic [1:0] ph;
  logic pv, pb;
  logic prev_blank;

  always #10 clk = ~clk;

  raster_line_gen i_raster_line_gen (
    .clk(clk), .rst_n(rst_n), .hsel_i(hsel), .vsel_i(vsel), .vbit_i(vbit),
    .blank_o(blank), .sync_o(sync), .video_o(video));

  function automatic logic f_blank(int pos);
    return pos < 48;
  endfunction
  function automatic logic f_sync(int pos);
    return pos >= 8 && pos < 24;
  endfunction
  function automatic logic f_video(int pos, logic [1:0] h, logic vs, logic vb);
    logic hs, vsrc;
    case (h)
      2'b01:   hs = pos[4];
      2'b10:   hs = (pos % 16) == 15;
      default: hs = 1'b1;
    endcase
    vsrc = vs ? vb : 1'b1;
    return f_blank(pos) ? 1'b0 : ~(hs & vsrc);
  endfunction

  task automatic cmp(string req, logic act, logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b (pos %0d)", req, act, exp, p);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  function automatic string vid_tag(logic [1:0] h, logic vs, int pos);
    if (f_blank(pos)) return "R7";
    if (h == 2'b01)   return "R4";
    if (h == 2'b10)   return "R5";
    if (vs)           return "R6";
    return "R7";
  endfunction

  // one cycle: outputs after the next edge reflect p and the current inputs (R8)
  task automatic step(logic [1:0] h, logic vs, logic vb);
    hsel = h; vsel = vs; vbit = vb;
    ph = h; pv = vs; pb = vb;
    @(posedge clk);
    @(negedge clk);
    cmp("R2", blank, f_blank(p));
    cmp("R3", sync, f_sync(p));
    cmp(vid_tag(ph, pv, p), video, f_video(p, ph, pv, pb));
    if (blank && !prev_blank) begin
      if (last_rise >= 0) cmp("R1", 1'b1, (samp - last_rise) == 256);
      last_rise = samp;
    end
    prev_blank = blank;
    samp++;
    p = (p + 1) % 256;
  endtask

  initial begin
    int wd = 0;
    forever begin
      @(posedge clk);
      wd++;
      if (wd > 150000) begin
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
      end
    end
  end

  initial begin
    void'($urandom(32'd1983));
    rst_n = 1'b0; hsel = 2'b00; vsel = 1'b0; vbit = 1'b0;
    p = 0; samp = 0; last_rise = -1; prev_blank = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    cmp("R9", blank, 1'b1);
    cmp("R9", sync, 1'b0);
    cmp("R9", video, 1'b0);
    rst_n = 1'b1;
    last_rise = 0;
    // random mix over several lines
    for (int i = 0; i < 900; i++)
      step(2'($urandom_range(0, 3)), 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
    // directed: stripes across a full line, vertical constant high (R4)
    for (int i = 0; i < 256; i++) step(2'b01, 1'b0, 1'b0);
    // directed: thin lines, vertical bit high (R5, R6)
    for (int i = 0; i < 256; i++) step(2'b10, 1'b1, 1'b1);
    // directed: flat source code 11, vertical bit low makes video high outside blank (R5, R6)
    for (int i = 0; i < 256; i++) step(2'b11, 1'b1, 1'b0);
    // directed R8: vbit toggles each cycle in flat mode; video follows the previous edge
    for (int i = 0; i < 256; i++) step(2'b00, 1'b1, 1'(i % 2));
    // mid-line reset (R9)
    for (int i = 0; i < 100; i++) step(2'b01, 1'b1, 1'b1);
    rst_n = 1'b0;
    #2;
    cmp("R9", blank, 1'b1);
    cmp("R9", sync, 1'b0);
    cmp("R9", video, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    p = 0; last_rise = samp; prev_blank = 1'b1;
    for (int i = 0; i < 600; i++)
      step(2'($urandom_range(0, 3)), 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
    finish_run();
  end
endmodule